// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Selective Status Update

This block is the combinational datapath of a small eight-bit RISC core. Each cycle the core gives it two operands (`a_i` from a register, `b_i` from a register or an immediate), the current carry and zero flags, and an operation code. The block returns the eight-bit result and a set of six status flags. It also returns a write mask that names the flags the operation updates. The core's status register loads only the masked bits and keeps the others.

The operations are:
- additions, with and without carry-in;
- subtractions and compares, with and without borrow-in;
- bitwise AND, OR and XOR, and a zero test;
- one's and two's complement;
- increment and decrement;
- logical shifts, arithmetic shift right and rotates through carry;
- a nibble exchange.

For multi-byte compare and subtract chains, the carry-chained forms combine the previous zero flag with the zero state of the current byte. A branch after the last byte then sees the result for the whole word.

Flag vector and mask bit positions: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 signed-test (S), bit 5 half-carry (H). N is always bit 7 of the result. Z is set when the result is zero, except where R3 says otherwise.

Top module: `alu8_core`

## Requirements
- R1: Op 0 (plain add) returns a+b and ignores c_in_i. Op 1 (add with carry) returns a+b+c_in_i. Both write mask 6'b111111, with C the carry out of bit 7, H the carry out of bit 3, and V set on two's-complement overflow.
- R2: Op 2 (subtract) and op 4 (compare) return a-b. Op 3 and op 5 (their carry-chained forms) return a-b-c_in_i. All four write mask 6'b111111, with C the borrow out of bit 7, H the borrow out of bit 3, and V set on signed overflow. Op 4 sets Z whenever the result is zero, whatever z_in_i holds.
- R3: For ops 3 and 5, Z is 1 only when the result is zero and z_in_i is 1. Otherwise Z is 0.
- R4: Ops 6 (AND), 7 (OR), 8 (XOR) and 13 (test, result = a) write mask 6'b011110 and always return V = 0.
- R5: Op 11 (increment) returns a+1 and sets V only for input 0x7F. Op 12 (decrement) returns a-1 and sets V only for input 0x80. Both write mask 6'b011110, so C is not written.
- R6: Op 9 (one's complement) returns 0xFF-a, with C = 1 and V = 0, under mask 6'b011111. Op 10 (two's complement) returns 0x00-a under mask 6'b111111. C is set when the result is nonzero, V is set only for 0x80, and H is set when bits 3..0 of a are nonzero.
- R7: Op 14 (shift left) fills bit 0 with 0 and sets C from bit 7. Op 15 (logical shift right) fills bit 7 with 0. Op 18 (arithmetic shift right) keeps bit 7. Ops 15 and 18 set C from bit 0. All use mask 6'b011111.
- R8: Op 16 (rotate left) moves c_in_i into bit 0 and bit 7 into C. Op 17 (rotate right) moves c_in_i into bit 7 and bit 0 into C. Both use mask 6'b011111.
- R9: For ops 14 to 18, V equals N XOR C of the new flags.
- R10: Whenever the mask includes N or V, it also includes S, and S equals N XOR V.
- R11: Op 19 (nibble swap) returns bits 3..0 of a in bits 7..4 and bits 7..4 in bits 3..0, with mask 0. Any code from 20 to 31 returns result 0 and mask 0.
- R12: Every bit of flags_o whose mask bit is 0 is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (values listed in the requirements) |
| a_i | input | 8 | First operand, the destination register |
| b_i | input | 8 | Second operand, a register or an immediate |
| c_in_i | input | 1 | Carry flag from the status register |
| z_in_i | input | 1 | Zero flag from the status register |
| res_o | output | 8 | Operation result |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| mask_o | output | 6 | Flags written by this operation, same bit order |

## Verification
The hardest overlap is in a carry-chained subtract or compare. There the borrow-in changes the arithmetic result while the previous zero flag gates Z in the same evaluation. The bench sets up the byte pairs where these two interact:
- equal bytes with z_in_i both high and low;
- bytes that differ by one with borrow-in, which gives a zero result only because of c_in_i;
- a zero minuend with borrow-in, which wraps and also raises C and H.

For each case the bench compares the expected Z, C and H against the result. A second overlap is where carry and signed overflow fall together (0x7F+1, 0x80-1, negating 0x80). There V, S and C must each keep their own meaning.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NIB = DW / 2;
  localparam int FW  = 6;

  localparam int FB_C = 0;
  localparam int FB_Z = 1;
  localparam int FB_N = 2;
  localparam int FB_V = 3;
  localparam int FB_S = 4;
  localparam int FB_H = 5;

  localparam logic [FW-1:0] MSK_ALL   = 6'b111111;
  localparam logic [FW-1:0] MSK_SHIFT = 6'b011111;
  localparam logic [FW-1:0] MSK_LOGIC = 6'b011110;
  localparam logic [FW-1:0] MSK_NONE  = 6'b000000;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_TST  = 5'd13,
    OP_LSL  = 5'd14,
    OP_LSR  = 5'd15,
    OP_ROL  = 5'd16,
    OP_ROR  = 5'd17,
    OP_ASR  = 5'd18,
    OP_SWAP = 5'd19
  } alu_op_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_OR   = 3'd1,
    LG_XOR  = 3'd2,
    LG_NOT  = 3'd3,
    LG_PASS = 3'd4
  } logic_kind_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ROL = 3'd2,
    SH_ROR = 3'd3,
    SH_ASR = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cy_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          hout_o,
  output logic          ovf_o
);
  logic [DW:0]  full_w;
  logic [NIB:0] low_w;

  // One carry chain for the whole byte and one for the low nibble; the
  // top bit of each is the carry (add) or the borrow (subtract).
  always_comb begin
    if (sub_i) begin
      full_w = {1'b0, x_i} - {1'b0, y_i} - {{DW{1'b0}}, cy_i};
      low_w  = {1'b0, x_i[NIB-1:0]} - {1'b0, y_i[NIB-1:0]} - {{NIB{1'b0}}, cy_i};
    end else begin
      full_w = {1'b0, x_i} + {1'b0, y_i} + {{DW{1'b0}}, cy_i};
      low_w  = {1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]} + {{NIB{1'b0}}, cy_i};
    end
  end

  assign sum_o  = full_w[DW-1:0];
  assign cout_o = full_w[DW];
  assign hout_o = low_w[NIB];

  // Signed overflow: operands of equal (add) or opposite (sub) sign
  // produce a result whose sign differs from the first operand.
  always_comb begin
    if (sub_i)
      ovf_o = (x_i[DW-1] != y_i[DW-1]) && (full_w[DW-1] != x_i[DW-1]);
    else
      ovf_o = (x_i[DW-1] == y_i[DW-1]) && (full_w[DW-1] != x_i[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic_kind_e   kind_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (kind_i)
      LG_AND:  res_o = x_i & y_i;
      LG_OR:   res_o = x_i | y_i;
      LG_XOR:  res_o = x_i ^ y_i;
      LG_NOT:  res_o = ~x_i;
      LG_PASS: res_o = x_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  shift_kind_e   kind_i,
  input  logic [DW-1:0] x_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o
);
  always_comb begin
    unique case (kind_i)
      SH_LSL: begin
        res_o  = {x_i[DW-2:0], 1'b0};
        cout_o = x_i[DW-1];
      end
      SH_LSR: begin
        res_o  = {1'b0, x_i[DW-1:1]};
        cout_o = x_i[0];
      end
      SH_ROL: begin
        res_o  = {x_i[DW-2:0], cy_i};
        cout_o = x_i[DW-1];
      end
      SH_ROR: begin
        res_o  = {cy_i, x_i[DW-1:1]};
        cout_o = x_i[0];
      end
      SH_ASR: begin
        res_o  = {x_i[DW-1], x_i[DW-1:1]};
        cout_o = x_i[0];
      end
      default: begin
        res_o  = '0;
        cout_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_in_i,
  input  logic          z_in_i,
  output logic [DW-1:0] res_o,
  output logic [FW-1:0] flags_o,
  output logic [FW-1:0] mask_o
);
  alu_op_e op_w;
  assign op_w = alu_op_e'(op_i);

  // Operand routing for the shared adder/subtractor.
  logic [DW-1:0] as_x, as_y, as_sum;
  logic          as_cy, as_sub, as_c, as_h, as_v;

  always_comb begin
    as_x   = a_i;
    as_y   = b_i;
    as_cy  = 1'b0;
    as_sub = 1'b0;
    unique case (op_w)
      OP_ADC:         as_cy = c_in_i;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC, OP_CPC: begin as_sub = 1'b1; as_cy = c_in_i; end
      OP_NEG:         begin as_sub = 1'b1; as_x = '0; as_y = a_i; end
      OP_INC:         as_y = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC:         begin as_sub = 1'b1; as_y = {{(DW-1){1'b0}}, 1'b1}; end
      default:        ;
    endcase
  end

  alu8_addsub u_addsub (
    .x_i    (as_x),
    .y_i    (as_y),
    .cy_i   (as_cy),
    .sub_i  (as_sub),
    .sum_o  (as_sum),
    .cout_o (as_c),
    .hout_o (as_h),
    .ovf_o  (as_v)
  );

  logic_kind_e   lg_kind;
  logic [DW-1:0] lg_res;

  always_comb begin
    unique case (op_w)
      OP_OR:   lg_kind = LG_OR;
      OP_XOR:  lg_kind = LG_XOR;
      OP_COM:  lg_kind = LG_NOT;
      OP_TST:  lg_kind = LG_PASS;
      default: lg_kind = LG_AND;
    endcase
  end

  alu8_logic u_logic (
    .kind_i (lg_kind),
    .x_i    (a_i),
    .y_i    (b_i),
    .res_o  (lg_res)
  );

  shift_kind_e   sh_kind;
  logic [DW-1:0] sh_res;
  logic          sh_c;

  always_comb begin
    unique case (op_w)
      OP_LSR:  sh_kind = SH_LSR;
      OP_ROL:  sh_kind = SH_ROL;
      OP_ROR:  sh_kind = SH_ROR;
      OP_ASR:  sh_kind = SH_ASR;
      default: sh_kind = SH_LSL;
    endcase
  end

  alu8_shift u_shift (
    .kind_i (sh_kind),
    .x_i    (a_i),
    .cy_i   (c_in_i),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  // Result selection and raw flag sources.
  logic [DW-1:0] res_w;
  logic [FW-1:0] msk_w;
  logic          c_w, h_w, v_w, v_from_nc, z_chain;

  always_comb begin
    res_w     = '0;
    msk_w     = MSK_NONE;
    c_w       = 1'b0;
    h_w       = 1'b0;
    v_w       = 1'b0;
    v_from_nc = 1'b0;
    z_chain   = 1'b0;
    unique case (op_w)
      OP_ADD, OP_ADC, OP_SUB, OP_CMP, OP_NEG: begin
        res_w = as_sum; c_w = as_c; h_w = as_h; v_w = as_v; msk_w = MSK_ALL;
      end
      OP_SBC, OP_CPC: begin
        res_w = as_sum; c_w = as_c; h_w = as_h; v_w = as_v; msk_w = MSK_ALL;
        z_chain = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res_w = as_sum; v_w = as_v; msk_w = MSK_LOGIC;
      end
      OP_AND, OP_OR, OP_XOR, OP_TST: begin
        res_w = lg_res; msk_w = MSK_LOGIC;
      end
      OP_COM: begin
        res_w = lg_res; c_w = 1'b1; msk_w = MSK_SHIFT;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res_w = sh_res; c_w = sh_c; v_from_nc = 1'b1; msk_w = MSK_SHIFT;
      end
      OP_SWAP: begin
        res_w = {a_i[NIB-1:0], a_i[DW-1:NIB]};
      end
      default: ;
    endcase
  end

  // Flag assembly: N, Z, V and S derived from the selected result.
  logic n_f, z_f, v_f, s_f;
  logic [FW-1:0] flg_w;

  always_comb begin
    n_f = res_w[DW-1];
    z_f = (res_w == '0) && (!z_chain || z_in_i);
    v_f = v_from_nc ? (n_f ^ c_w) : v_w;
    s_f = n_f ^ v_f;
    flg_w = '0;
    flg_w[FB_C] = c_w;
    flg_w[FB_Z] = z_f;
    flg_w[FB_N] = n_f;
    flg_w[FB_V] = v_f;
    flg_w[FB_S] = s_f;
    flg_w[FB_H] = h_w;
  end

  assign res_o   = res_w;
  assign mask_o  = msk_w;
  assign flags_o = flg_w & msk_w;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [4:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic          z_in_i,
  input logic [DW-1:0] res_o,
  input logic [FW-1:0] flags_o,
  input logic [FW-1:0] mask_o
);
  always_comb begin
    // R12: unmasked flag bits stay low
    assert_unmasked_low_R12: assert ((flags_o & ~mask_o) == '0)
      else $error("unmasked flag driven");

    // R10: S accompanies N/V and equals their XOR
    if (mask_o[FB_N] || mask_o[FB_V]) begin
      assert_sign_test_R10: assert (mask_o[FB_S] &&
                                    (flags_o[FB_S] == (flags_o[FB_N] ^ flags_o[FB_V])))
        else $error("signed-test flag wrong");
    end

    // R3: chained ops never raise Z when previous Z is low
    if ((op_i == 5'd3 || op_i == 5'd5) && !z_in_i) begin
      assert_chain_zero_R3: assert (!flags_o[FB_Z])
        else $error("chained zero raised");
    end

    // R4: logical ops clear V
    if (op_i == 5'd6 || op_i == 5'd7 || op_i == 5'd8 || op_i == 5'd13) begin
      assert_logic_v_clear_R4: assert (!flags_o[FB_V] && mask_o == MSK_LOGIC)
        else $error("logic op V or mask wrong");
    end

    // R9: shift/rotate overflow equals N xor C
    if (op_i >= 5'd14 && op_i <= 5'd18) begin
      assert_shift_v_R9: assert (flags_o[FB_V] == (flags_o[FB_N] ^ flags_o[FB_C]))
        else $error("shift V wrong");
    end

    // R11: swap writes no flag and exchanges nibbles
    if (op_i == 5'd19) begin
      assert_swap_quiet_R11: assert (mask_o == '0 &&
                                     res_o == {a_i[NIB-1:0], a_i[DW-1:NIB]})
        else $error("swap wrong");
    end
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .op_i    (op_i),
  .a_i     (a_i),
  .z_in_i  (z_in_i),
  .res_o   (res_o),
  .flags_o (flags_o),
  .mask_o  (mask_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk;
  logic [4:0] op;
  logic [7:0] a, b;
  logic       cin, zin;
  logic [7:0] res;
  logic [5:0] flags, mask;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [5:0] M_ALL = 6'b111111;
  localparam logic [5:0] M_SHF = 6'b011111;
  localparam logic [5:0] M_LOG = 6'b011110;
  localparam logic [5:0] M_NON = 6'b000000;

  alu8_core uut (
    .op_i    (op),
    .a_i     (a),
    .b_i     (b),
    .c_in_i  (cin),
    .z_in_i  (zin),
    .res_o   (res),
    .flags_o (flags),
    .mask_o  (mask)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Apply one operation on the falling edge, sample mid-way to the rising edge.
  task automatic run(input string tag, input logic [4:0] o, input logic [7:0] xa,
                     input logic [7:0] xb, input logic xc, input logic xz,
                     input logic [7:0] er, input logic [5:0] ef, input logic [5:0] em);
    @(negedge clk);
    op = o; a = xa; b = xb; cin = xc; zin = xz;
    #2;
    checks++;
    if (res !== er || flags !== ef || mask !== em) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h c=%b z=%b got res=%h flags=%b mask=%b exp res=%h flags=%b mask=%b",
               tag, o, xa, xb, xc, xz, res, flags, mask, er, ef, em);
    end
  endtask

  task automatic t_idle;
    run("R11 undefined code 31", 5'd31, 8'hA7, 8'h3C, 1'b1, 1'b1, 8'h00, 6'b0, M_NON);
    run("R11 undefined code 20", 5'd20, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00, 6'b0, M_NON);
  endtask

  task automatic t_add;
    run("R1 add half carry, cin ignored", 5'd0, 8'h0F, 8'h01, 1'b1, 1'b0, 8'h10, 6'b100000, M_ALL);
    run("R1 add signed overflow",         5'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 6'b101100, M_ALL);
    run("R1 adc carry and zero",          5'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 6'b100011, M_ALL);
  endtask

  task automatic t_sub;
    run("R2 sub half borrow",      5'd2, 8'h10, 8'h01, 1'b0, 1'b0, 8'h0F, 6'b100000, M_ALL);
    run("R2 sub wrap borrow",      5'd2, 8'h00, 8'h01, 1'b1, 1'b0, 8'hFF, 6'b110101, M_ALL);
    run("R2 sub signed overflow",  5'd2, 8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 6'b111000, M_ALL);
    run("R2 cmp equal, z_in low",  5'd4, 8'h42, 8'h42, 1'b0, 1'b0, 8'h00, 6'b000010, M_ALL);
  endtask

  task automatic t_chain;
    run("R3 sbc equal z_in high",     5'd3, 8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 6'b000010, M_ALL);
    run("R3 sbc equal z_in low",      5'd3, 8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 6'b000000, M_ALL);
    run("R3 sbc zero via borrow-in",  5'd3, 8'h05, 8'h04, 1'b1, 1'b1, 8'h00, 6'b000010, M_ALL);
    run("R3 sbc wrap with borrow-in", 5'd3, 8'h00, 8'h00, 1'b1, 1'b1, 8'hFF, 6'b110101, M_ALL);
    run("R3 cpc zero but z_in low",   5'd5, 8'h42, 8'h41, 1'b1, 1'b0, 8'h00, 6'b000000, M_ALL);
    run("R3 cpc zero with z_in high", 5'd5, 8'h42, 8'h41, 1'b1, 1'b1, 8'h00, 6'b000010, M_ALL);
  endtask

  task automatic t_logic;
    run("R4 and",           5'd6,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 6'b000000, M_LOG);
    run("R4 or negative",   5'd7,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 6'b010100, M_LOG);
    run("R4 xor zero",      5'd8,  8'h55, 8'h55, 1'b0, 1'b0, 8'h00, 6'b000010, M_LOG);
    run("R4 test negative", 5'd13, 8'h80, 8'h00, 1'b1, 1'b0, 8'h80, 6'b010100, M_LOG);
  endtask

  task automatic t_incdec;
    run("R5 inc overflow",   5'd11, 8'h7F, 8'hAA, 1'b0, 1'b0, 8'h80, 6'b001100, M_LOG);
    run("R5 inc wrap no C",  5'd11, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 6'b000010, M_LOG);
    run("R5 dec overflow",   5'd12, 8'h80, 8'h00, 1'b1, 1'b0, 8'h7F, 6'b011000, M_LOG);
    run("R5 dec to zero",    5'd12, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 6'b000010, M_LOG);
  endtask

  task automatic t_compl;
    run("R6 com of zero",      5'd9,  8'h00, 8'hAA, 1'b0, 1'b0, 8'hFF, 6'b010101, M_SHF);
    run("R6 com to zero",      5'd9,  8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 6'b000011, M_SHF);
    run("R6 neg of one",       5'd10, 8'h01, 8'h55, 1'b1, 1'b0, 8'hFF, 6'b110101, M_ALL);
    run("R6 neg of zero",      5'd10, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 6'b000010, M_ALL);
    run("R6 neg of 0x80",      5'd10, 8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 6'b001101, M_ALL);
  endtask

  task automatic t_shift;
    run("R7 R9 lsl carry out",  5'd14, 8'h81, 8'h00, 1'b1, 1'b0, 8'h02, 6'b011001, M_SHF);
    run("R7 R9 lsl into sign",  5'd14, 8'h40, 8'h00, 1'b0, 1'b0, 8'h80, 6'b001100, M_SHF);
    run("R7 R9 lsr to zero",    5'd15, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 6'b011011, M_SHF);
    run("R7 R9 asr keeps sign", 5'd18, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 6'b010101, M_SHF);
    run("R7 asr positive",      5'd18, 8'h02, 8'h00, 1'b1, 1'b0, 8'h01, 6'b000000, M_SHF);
  endtask

  task automatic t_rotate;
    run("R8 R9 rol through carry", 5'd16, 8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 6'b011001, M_SHF);
    run("R8 rol carry-in low",     5'd16, 8'h01, 8'h00, 1'b0, 1'b0, 8'h02, 6'b000000, M_SHF);
    run("R8 R9 ror through carry", 5'd17, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 6'b010101, M_SHF);
  endtask

  task automatic t_swap;
    run("R11 R12 swap no flags", 5'd19, 8'hA5, 8'hFF, 1'b1, 1'b1, 8'h5A, 6'b000000, M_NON);
    run("R10 R12 sign via sub",  5'd2,  8'h01, 8'h02, 1'b0, 1'b0, 8'hFF, 6'b110101, M_ALL);
  endtask

  initial begin
    op = 5'd31; a = '0; b = '0; cin = 1'b0; zin = 1'b0;
    repeat (3) @(posedge clk);
    t_idle;
    t_add;
    t_sub;
    t_chain;
    t_logic;
    t_incdec;
    t_compl;
    t_shift;
    t_rotate;
    t_swap;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule